// File: doc/BRIEF.md
# Parallel Port Configuration Unlock Sequencer

This block guards the configuration registers of an on-chip parallel port. It watches a byte-wide I/O write strobe. Configuration stays closed until a key byte has been written twice in a row to the index address (3F0h). Any other write while closed starts the key count again. Once the interface is open, a byte written to the index address selects a register. A byte written to the data address (3F1h) updates the selected register. A dedicated close key written to the index address shuts the interface again.

Two registers exist. The select register chooses the port's I/O base address or turns the port off. The mode register holds two option bits. The block decodes the select register into a base address and an enable flag for the port logic. It also presents the raw register contents. All results are registered and appear the cycle after the write that caused them.

Top module: `pp_cfg_unlock`

## Requirements
- R1: After reset the interface is closed, the index is 00h, the select register reads 9Fh, the mode register reads 00h, the base address is 278h and the port is enabled.
- R2: Two back-to-back writes of 55h to address 3F0h open the interface; the open flag rises the cycle after the second write.
- R3: While closed, any write that is not 55h to 3F0h (another value, or any value to any other address) clears the key count, so a following single 55h does not open the interface.
- R4: While open, a write of AAh to 3F0h closes the interface in the next cycle.
- R5: While open, a write of any value other than AAh to 3F0h becomes the register index.
- R6: An open data write (address 3F1h) with index 01h stores bit 3 and bits 1:0 of the byte into the select register; bits 7 and 2 always read 1 and bits 6:4 read 0 after such a write.
- R7: Select register bits 1:0 map to the port base: 1 gives 3BCh, 2 gives 378h, 3 gives 278h, and 0 disables the port with a base of 0000h.
- R8: An open data write with index 04h stores only bits 1:0 of the byte into the mode register; its other bits read 0.
- R9: Data writes while closed, data writes with an index other than 01h or 04h, and open writes to addresses other than 3F0h/3F1h leave both registers unchanged.
- R10: The key count saturates once open: further 55h writes to 3F0h keep the interface open and are taken as an index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 16 | I/O write address |
| io_wdata | input | 8 | I/O write data byte |
| cfg_open | output | 1 | Configuration interface is open |
| cfg_index | output | 8 | Current register index |
| sel_reg | output | 8 | Select register contents |
| mode_reg | output | 8 | Mode register contents |
| port_base | output | 16 | Decoded parallel port base address |
| port_en | output | 1 | Parallel port enabled |

## Verification
Every result comes out of one register stage. The open flag, the index and both registers change on the clock edge that samples the write. The decoded base and enable follow the select register through combinational logic, so they are due in that same cycle. The bench drives each write for one cycle from a falling edge and advances its behavioural model on the rising edge. It compares every output on the next falling edge, one cycle after the stimulus. Directed checks tied to each requirement are sampled at that same point.

// File: rtl/ppcfg_pkg.sv
package ppcfg_pkg;

    localparam int unsigned PP_DW = 8;

    // Address-select field encoding held in select register bits 1:0
    typedef enum logic [1:0] {
        SLOT_OFF  = 2'd0,
        SLOT_MONO = 2'd1,
        SLOT_PRI  = 2'd2,
        SLOT_SEC  = 2'd3
    } pp_slot_e;

    typedef struct packed {
        logic [PP_DW-1:0] index;
        logic [PP_DW-1:0] sel;
        logic [PP_DW-1:0] mode;
    } pp_regs_t;

endpackage

// File: rtl/ppcfg_keyseq.sv
module ppcfg_keyseq #(
    parameter int unsigned       AW        = 16,
    parameter int unsigned       DW        = 8,
    parameter logic [AW-1:0]     IDX_ADDR  = 16'h03F0,
    parameter logic [AW-1:0]     DAT_ADDR  = 16'h03F1,
    parameter logic [DW-1:0]     OPEN_KEY  = 8'h55,
    parameter logic [DW-1:0]     CLOSE_KEY = 8'hAA,
    parameter int unsigned       KEY_COUNT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          open_o,
    output logic          idx_ld_o,
    output logic          dat_wr_o
);

    localparam int unsigned     CW       = $clog2(KEY_COUNT + 1);
    localparam logic [CW-1:0]   FULL     = CW'(KEY_COUNT);
    localparam logic [CW-1:0]   ALMOST   = CW'(KEY_COUNT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic hit_idx;
    logic is_open_key;
    logic is_close_key;

    assign hit_idx      = (addr == IDX_ADDR);
    assign is_open_key  = hit_idx && (wdata == OPEN_KEY);
    assign is_close_key = hit_idx && (wdata == CLOSE_KEY);

    always_comb begin
        seq_d = seq_q;
        if (wr) begin
            if (seq_q.cnt != FULL) begin
                seq_d.cnt = is_open_key ? seq_q.cnt + CW'(1) : '0;
            end else if (is_close_key) begin
                seq_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign open_o   = (seq_q.cnt == FULL);
    assign idx_ld_o = wr && open_o && hit_idx && !is_close_key;
    assign dat_wr_o = wr && open_o && (addr == DAT_ADDR);

    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.cnt <= FULL);

    p_break_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !open_o && !is_open_key) |=> (seq_q.cnt == '0));

    p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (seq_q.cnt == ALMOST) && is_open_key) |=> open_o);

    p_relock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && open_o && is_close_key) |=> !open_o);

    p_stay_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && !(wr && is_close_key)) |=> open_o);

endmodule

// File: rtl/ppcfg_regs.sv
module ppcfg_regs
    import ppcfg_pkg::*;
#(
    parameter logic [PP_DW-1:0] SEL_IDX    = 8'h01,
    parameter logic [PP_DW-1:0] MODE_IDX   = 8'h04,
    parameter logic [PP_DW-1:0] SEL_RST    = 8'h9F,
    parameter logic [PP_DW-1:0] FIXED_ONES = 8'h84,
    parameter logic [PP_DW-1:0] SEL_KEEP   = 8'h0B,
    parameter logic [PP_DW-1:0] MODE_KEEP  = 8'h03
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_ld,
    input  logic             dat_wr,
    input  logic [PP_DW-1:0] wdata,
    output logic [PP_DW-1:0] index_o,
    output logic [PP_DW-1:0] sel_o,
    output logic [PP_DW-1:0] mode_o
);

    pp_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (idx_ld) begin
            regs_d.index = wdata;
        end
        if (dat_wr) begin
            if (regs_q.index == SEL_IDX) begin
                regs_d.sel = (wdata & SEL_KEEP) | FIXED_ONES;
            end else if (regs_q.index == MODE_IDX) begin
                regs_d.mode = wdata & MODE_KEEP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.index <= '0;
            regs_q.sel   <= SEL_RST;
            regs_q.mode  <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign index_o = regs_q.index;
    assign sel_o   = regs_q.sel;
    assign mode_o  = regs_q.mode;

    p_fixed_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.sel & FIXED_ONES) == FIXED_ONES);

    p_mode_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.mode & ~MODE_KEEP) == '0);

    p_other_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && (regs_q.index != SEL_IDX) && (regs_q.index != MODE_IDX))
        |=> ($stable(regs_q.sel) && $stable(regs_q.mode)));

    p_no_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_wr |=> ($stable(regs_q.sel) && $stable(regs_q.mode)));

endmodule

// File: rtl/ppcfg_decode.sv
module ppcfg_decode
    import ppcfg_pkg::*;
#(
    parameter int unsigned   AW        = 16,
    parameter logic [AW-1:0] BASE_MONO = 16'h03BC,
    parameter logic [AW-1:0] BASE_PRI  = 16'h0378,
    parameter logic [AW-1:0] BASE_SEC  = 16'h0278
) (
    input  logic [1:0]    slot,
    output logic [AW-1:0] base_o,
    output logic          en_o
);

    pp_slot_e slot_e;
    assign slot_e = pp_slot_e'(slot);

    always_comb begin
        en_o   = 1'b1;
        base_o = '0;
        unique case (slot_e)
            SLOT_MONO: base_o = BASE_MONO;
            SLOT_PRI:  base_o = BASE_PRI;
            SLOT_SEC:  base_o = BASE_SEC;
            default:   en_o   = 1'b0;
        endcase
    end

endmodule

// File: rtl/pp_cfg_unlock.sv
module pp_cfg_unlock
    import ppcfg_pkg::*;
#(
    parameter int unsigned        AW        = 16,
    parameter logic [AW-1:0]      IDX_ADDR  = 16'h03F0,
    parameter logic [AW-1:0]      DAT_ADDR  = 16'h03F1,
    parameter logic [PP_DW-1:0]   OPEN_KEY  = 8'h55,
    parameter logic [PP_DW-1:0]   CLOSE_KEY = 8'hAA,
    parameter int unsigned        KEY_COUNT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_wr,
    input  logic [AW-1:0]    io_addr,
    input  logic [PP_DW-1:0] io_wdata,
    output logic             cfg_open,
    output logic [PP_DW-1:0] cfg_index,
    output logic [PP_DW-1:0] sel_reg,
    output logic [PP_DW-1:0] mode_reg,
    output logic [AW-1:0]    port_base,
    output logic             port_en
);

    logic idx_ld;
    logic dat_wr;

    ppcfg_keyseq #(
        .AW       (AW),
        .DW       (PP_DW),
        .IDX_ADDR (IDX_ADDR),
        .DAT_ADDR (DAT_ADDR),
        .OPEN_KEY (OPEN_KEY),
        .CLOSE_KEY(CLOSE_KEY),
        .KEY_COUNT(KEY_COUNT)
    ) u_keyseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (io_wr),
        .addr    (io_addr),
        .wdata   (io_wdata),
        .open_o  (cfg_open),
        .idx_ld_o(idx_ld),
        .dat_wr_o(dat_wr)
    );

    ppcfg_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_ld (idx_ld),
        .dat_wr (dat_wr),
        .wdata  (io_wdata),
        .index_o(cfg_index),
        .sel_o  (sel_reg),
        .mode_o (mode_reg)
    );

    ppcfg_decode #(
        .AW(AW)
    ) u_decode (
        .slot  (sel_reg[1:0]),
        .base_o(port_base),
        .en_o  (port_en)
    );

    p_en_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
        port_en == (port_base != '0));

    p_closed_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> ($stable(sel_reg) && $stable(mode_reg)));

endmodule

// File: tb/tb_pp_cfg_unlock.sv
module tb_pp_cfg_unlock;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        cfg_open;
    logic [7:0]  cfg_index;
    logic [7:0]  sel_reg;
    logic [7:0]  mode_reg;
    logic [15:0] port_base;
    logic        port_en;

    int errors = 0;
    int checks = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    pp_cfg_unlock dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .cfg_open(cfg_open), .cfg_index(cfg_index),
        .sel_reg(sel_reg), .mode_reg(mode_reg), .port_base(port_base),
        .port_en(port_en)
    );

    // Behavioural reference model
    int m_keys = 0;
    int m_idx  = 0;
    int m_sel  = 'h9F;
    int m_mode = 0;

    function automatic int exp_base(int s);
        case (s % 4)
            1: return 'h3BC;
            2: return 'h378;
            3: return 'h278;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_keys = 0; m_idx = 0; m_sel = 'h9F; m_mode = 0;
        end else if (io_wr) begin
            if (m_keys < 2) begin
                if (io_addr == 16'h3F0 && io_wdata == 8'h55) m_keys = m_keys + 1;
                else m_keys = 0;
            end else if (io_addr == 16'h3F0) begin
                if (io_wdata == 8'hAA) m_keys = 0;
                else m_idx = io_wdata;
            end else if (io_addr == 16'h3F1) begin
                if (m_idx == 1) m_sel = 'h84 | (io_wdata & 'h0B);
                else if (m_idx == 4) m_mode = io_wdata & 'h03;
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Full comparison each cycle, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(phase, "open",  int'(cfg_open),  int'(m_keys == 2));
            chk(phase, "index", int'(cfg_index), m_idx);
            chk(phase, "sel",   int'(sel_reg),   m_sel);
            chk(phase, "mode",  int'(mode_reg),  m_mode);
            chk(phase, "base",  int'(port_base), exp_base(m_sel));
            chk(phase, "en",    int'(port_en),   int'((m_sel % 4) != 0));
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        phase = "R1";
        chk("R1", "reset open",  int'(cfg_open), 0);
        chk("R1", "reset index", int'(cfg_index), 0);
        chk("R1", "reset sel",   int'(sel_reg), 'h9F);
        chk("R1", "reset mode",  int'(mode_reg), 0);
        chk("R1", "reset base",  int'(port_base), 'h278);
        chk("R1", "reset en",    int'(port_en), 1);

        phase = "R9";
        wr(16'h3F1, 8'h00);
        chk("R9", "closed data write sel", int'(sel_reg), 'h9F);

        phase = "R3";
        wr(16'h3F0, 8'h55); wr(16'h3F1, 8'h12); wr(16'h3F0, 8'h55);
        chk("R3", "other address breaks key", int'(cfg_open), 0);
        wr(16'h3F0, 8'h66); wr(16'h3F0, 8'h55);
        chk("R3", "other value breaks key", int'(cfg_open), 0);

        phase = "R2";
        wr(16'h3F0, 8'h55);
        chk("R2", "two keys open", int'(cfg_open), 1);

        phase = "R10";
        wr(16'h3F0, 8'h55);
        chk("R10", "extra key stays open", int'(cfg_open), 1);
        chk("R10", "extra key is index", int'(cfg_index), 'h55);

        phase = "R5";
        wr(16'h3F0, 8'h01);
        chk("R5", "index load", int'(cfg_index), 1);

        phase = "R6";
        wr(16'h3F1, 8'hFF);
        chk("R6", "sel masked", int'(sel_reg), 'h8F);
        phase = "R7";
        wr(16'h3F1, 8'h01);
        chk("R7", "base 3BC", int'(port_base), 'h3BC);
        wr(16'h3F1, 8'h02);
        chk("R7", "base 378", int'(port_base), 'h378);
        wr(16'h3F1, 8'h00);
        chk("R7", "disabled en", int'(port_en), 0);
        chk("R7", "disabled base", int'(port_base), 0);
        chk("R6", "fixed ones", int'(sel_reg), 'h84);
        wr(16'h3F1, 8'h73);
        chk("R6", "upper bits dropped", int'(sel_reg), 'h87);

        phase = "R8";
        wr(16'h3F0, 8'h04); wr(16'h3F1, 8'hFE);
        chk("R8", "mode masked", int'(mode_reg), 'h02);
        wr(16'h3F1, 8'hFF);
        chk("R8", "mode both bits", int'(mode_reg), 'h03);

        phase = "R9";
        wr(16'h3F0, 8'h07); wr(16'h3F1, 8'h00);
        chk("R9", "other index sel", int'(sel_reg), 'h87);
        chk("R9", "other index mode", int'(mode_reg), 'h03);
        wr(16'h0080, 8'hAA);
        chk("R9", "foreign address keeps open", int'(cfg_open), 1);
        chk("R9", "foreign address index", int'(cfg_index), 'h07);

        phase = "R4";
        wr(16'h3F0, 8'hAA);
        chk("R4", "close key", int'(cfg_open), 0);
        chk("R4", "index kept", int'(cfg_index), 'h07);
        wr(16'h3F0, 8'h55); wr(16'h3F0, 8'h55); wr(16'h3F0, 8'h01);
        wr(16'h3F0, 8'hAA); wr(16'h3F1, 8'h01);
        chk("R9", "closed write after relock", int'(sel_reg), 'h87);

        repeat (2) @(negedge clk);
        summary();
    end

endmodule